// File: doc/BRIEF.md
# Packed Double-Precision Subtract Unit

This execution unit subtracts IEEE-754 binary64 values lane by lane across a 256-bit vector. Each 64-bit lane computes its first operand minus its second operand. It rounds to nearest with ties to even, handles subnormal operands exactly, and resolves infinities and NaNs by fixed rules. No lane affects any other lane.

A two-bit mode input sets how much of the vector is computed and what lands in the upper 128 bits. In the in-place 128-bit form, the upper half keeps the old destination contents. In the three-operand 128-bit form, the upper half is cleared. In the 256-bit form, all four lanes are computed. A separate destination input supplies the old contents for the in-place form.

Five exception flags are ORed over the lanes that are actually computed. Result and flags are registered and appear one clock after the input strobe, marked by an output valid.

Top module: `pfp_sub_unit`

## Requirements
- R1: Lane i occupies bits [64*i+63:64*i]. Every computed lane returns first operand minus second operand, correctly rounded to nearest with ties to even, independent of the other lanes.
- R2: Mode 2'b10 computes all four lanes. Mode 2'b11 behaves exactly like 2'b10.
- R3: Mode 2'b00 computes lanes 0 and 1 and copies bits [255:128] of the old destination input to the result unchanged.
- R4: Mode 2'b01 computes lanes 0 and 1 and writes bits [255:128] of the result as zero.
- R5: An exact zero difference of operands with unlike effective signs is +0. Two zeros with the same effective sign keep that sign, so (-0)-(+0) gives -0.
- R6: A signalling NaN on either input, or infinity minus an infinity of the same sign, returns 64'hFFF8000000000000 and sets the invalid flag (flags bit 0).
- R7: With no signalling NaN present, a quiet NaN first operand is returned unchanged. Otherwise a quiet NaN second operand is returned unchanged. Neither case sets invalid, overflow, underflow or inexact.
- R8: A finite result too large for the format returns an infinity of the result's sign and sets overflow (bit 2) and inexact (bit 4).
- R9: Inexact (bit 4) is set when rounding discards nonzero bits. Underflow (bit 3) is set only for a result that is tiny before rounding and inexact, so an exact subnormal difference leaves it clear.
- R10: An input with a zero exponent field and a nonzero fraction sets the denormal flag (bit 1) and takes part in the subtraction at its exact subnormal value.
- R11: The flags output is the OR of the per-lane flags of the computed lanes only. Lanes that are kept or zeroed contribute nothing.
- R12: Result and flags are captured on the clock edge where in_valid is high, and out_valid is high for exactly the following cycle. Reset clears out_valid, result and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| mode | input | 2 | 00 in-place 128, 01 zero-upper 128, 10/11 full 256 |
| src1 | input | 256 | First operands (minuends), four lanes |
| src2 | input | 256 | Second operands (subtrahends), four lanes |
| dst_old | input | 256 | Prior destination contents for the in-place mode |
| out_valid | output | 1 | Result and flags valid |
| result | output | 256 | Differences and upper-lane contents |
| flags | output | 5 | {inexact, underflow, overflow, denormal, invalid} |

## Verification
Random operand pairs come with exponents drawn close together, which forces deep cancellation and exact results. They also come with exponents far apart, which produces sticky-bit rounding and inexact results. Mixed in are subnormals, zeros, infinities and both kinds of NaN, so each special-value priority gets separated from ordinary arithmetic. Directed cases pin ties that must round to even, largest-magnitude operands that overflow, signed zero results, and lane 2 inputs that would raise invalid under each mode. The masked-lane cases show whether flags and data from uncomputed lanes leak into the output.

// File: rtl/fpsub_pkg.sv
package fpsub_pkg;

  localparam int LANE_W = 64;
  localparam int EXP_W  = 11;
  localparam int FRAC_W = 52;
  localparam int MAN_W  = FRAC_W + 1;
  localparam int ALN_W  = MAN_W + 4;   // carry + mantissa + guard/round/sticky
  localparam int NRM_W  = ALN_W - 1;
  localparam int XE_W   = EXP_W + 2;
  localparam int LZ_W   = 7;

  localparam logic [LANE_W-1:0] QNAN_DEFAULT = 64'hFFF8_0000_0000_0000;
  localparam logic [EXP_W-1:0]  EXP_ONES     = '1;
  localparam logic [XE_W-1:0]   EXP_LIMIT    = XE_W'((1 << EXP_W) - 1);

  typedef enum logic [1:0] {
    MODE_KEEP_HI = 2'b00,
    MODE_ZERO_HI = 2'b01,
    MODE_FULL    = 2'b10,
    MODE_FULL_X  = 2'b11
  } sub_mode_e;

  typedef struct packed {
    logic inexact;
    logic underflow;
    logic overflow;
    logic denormal;
    logic invalid;
  } fp_flags_t;

  // Leading zero count of a normalization window; NRM_W when all zero.
  function automatic logic [LZ_W-1:0] lead_zeros(input logic [NRM_W-1:0] v);
    logic [LZ_W-1:0] n;
    n = LZ_W'(NRM_W);
    for (int i = 0; i < NRM_W; i++) begin
      if (v[i]) n = LZ_W'(NRM_W - 1 - i);
    end
    return n;
  endfunction

  // Right shift that folds every bit shifted out into bit 0.
  function automatic logic [ALN_W-1:0] shr_sticky(input logic [ALN_W-1:0] v,
                                                   input logic [XE_W-1:0]  sh);
    logic [ALN_W-1:0] mask;
    logic [ALN_W-1:0] r;
    if (sh >= XE_W'(ALN_W)) begin
      r = '0;
      r[0] = |v;
    end else begin
      mask = (ALN_W'(1) << sh) - ALN_W'(1);
      r = v >> sh;
      r[0] = r[0] | (|(v & mask));
    end
    return r;
  endfunction

  // Nearest-even increment decision.
  function automatic logic round_inc(input logic lsb, input logic g, input logic rs);
    return g & (rs | lsb);
  endfunction

endpackage

// File: rtl/fpsub_lane.sv
module fpsub_lane
  import fpsub_pkg::*;
(
  input  logic [LANE_W-1:0] op_a,
  input  logic [LANE_W-1:0] op_b,
  output logic [LANE_W-1:0] diff,
  output fp_flags_t         flg
);

  // Operand fields; the second operand's sign is flipped for the add.
  logic              sa, sb;
  logic [EXP_W-1:0]  ea, eb;
  logic [FRAC_W-1:0] fa, fb;
  assign sa = op_a[LANE_W-1];
  assign sb = ~op_b[LANE_W-1];
  assign ea = op_a[LANE_W-2:FRAC_W];
  assign eb = op_b[LANE_W-2:FRAC_W];
  assign fa = op_a[FRAC_W-1:0];
  assign fb = op_b[FRAC_W-1:0];

  // Classification events
  logic a_nan, b_nan, a_snan, b_snan, a_inf, b_inf, a_den, b_den;
  assign a_nan  = (ea == EXP_ONES) && (|fa);
  assign b_nan  = (eb == EXP_ONES) && (|fb);
  assign a_snan = a_nan && !fa[FRAC_W-1];
  assign b_snan = b_nan && !fb[FRAC_W-1];
  assign a_inf  = (ea == EXP_ONES) && !(|fa);
  assign b_inf  = (eb == EXP_ONES) && !(|fb);
  assign a_den  = (ea == '0) && (|fa);
  assign b_den  = (eb == '0) && (|fb);

  // Unpacked significands; subnormals use exponent 1 and no hidden bit
  logic [MAN_W-1:0] ma, mb;
  logic [XE_W-1:0]  xa, xb;
  assign ma = {|ea, fa};
  assign mb = {|eb, fb};
  assign xa = (|ea) ? XE_W'(ea) : XE_W'(1);
  assign xb = (|eb) ? XE_W'(eb) : XE_W'(1);

  // Order by magnitude so the difference of significands is never negative
  logic             a_big;
  logic             xs, ys;
  logic [XE_W-1:0]  xe, ye;
  logic [MAN_W-1:0] xm, ym;
  assign a_big = {xa, ma} >= {xb, mb};
  assign xs = a_big ? sa : sb;
  assign ys = a_big ? sb : sa;
  assign xe = a_big ? xa : xb;
  assign ye = a_big ? xb : xa;
  assign xm = a_big ? ma : mb;
  assign ym = a_big ? mb : ma;

  logic             eff_sub;
  logic [ALN_W-1:0] big_al, sml_al, sum;
  assign eff_sub = xs ^ ys;
  assign big_al  = {1'b0, xm, 3'b000};
  assign sml_al  = shr_sticky({1'b0, ym, 3'b000}, xe - ye);
  assign sum     = eff_sub ? (big_al - sml_al) : (big_al + sml_al);

  // Normalization, clamped so the exponent never drops below 1
  logic             carry_out;
  logic [LZ_W-1:0]  lz;
  logic [XE_W-1:0]  lim, sh_l, ne;
  logic [NRM_W-1:0] nrm;
  assign carry_out = sum[ALN_W-1];
  assign lz   = lead_zeros(sum[NRM_W-1:0]);
  assign lim  = xe - XE_W'(1);
  assign sh_l = (XE_W'(lz) > lim) ? lim : XE_W'(lz);

  always_comb begin
    if (carry_out) begin
      nrm = {sum[ALN_W-1:2], sum[1] | sum[0]};
      ne  = xe + XE_W'(1);
    end else begin
      nrm = sum[NRM_W-1:0] << sh_l;
      ne  = xe - sh_l;
    end
  end

  // Rounding
  logic             g_bit, rs_bit, rnd_up, inx_raw, tiny, hid, ovf_raw, zero_res, rsign;
  logic [MAN_W:0]   mr;
  logic [XE_W-1:0]  re;
  logic [EXP_W-1:0] exp_field;
  logic [FRAC_W-1:0] frac_out;
  assign g_bit   = nrm[2];
  assign rs_bit  = nrm[1] | nrm[0];
  assign rnd_up  = round_inc(nrm[3], g_bit, rs_bit);
  assign inx_raw = g_bit | rs_bit;
  assign mr      = {1'b0, nrm[NRM_W-1:3]} + (MAN_W+1)'(rnd_up);
  assign re      = mr[MAN_W] ? (ne + XE_W'(1)) : ne;
  assign hid     = mr[MAN_W] | mr[MAN_W-1];
  assign frac_out = mr[MAN_W] ? '0 : mr[FRAC_W-1:0];
  assign exp_field = hid ? re[EXP_W-1:0] : '0;
  assign tiny    = !nrm[NRM_W-1];
  assign ovf_raw = hid && (re >= EXP_LIMIT);
  assign zero_res = (sum == '0);
  assign rsign   = zero_res ? (eff_sub ? 1'b0 : xs) : xs;

  // Special-value priority and final packing
  always_comb begin
    flg = '0;
    flg.denormal = a_den | b_den;
    if (a_snan || b_snan) begin
      diff = QNAN_DEFAULT;
      flg.invalid = 1'b1;
    end else if (a_nan) begin
      diff = op_a;
    end else if (b_nan) begin
      diff = op_b;
    end else if (a_inf && b_inf && (op_a[LANE_W-1] == op_b[LANE_W-1])) begin
      diff = QNAN_DEFAULT;
      flg.invalid = 1'b1;
    end else if (a_inf) begin
      diff = op_a;
    end else if (b_inf) begin
      diff = {sb, op_b[LANE_W-2:0]};
    end else if (ovf_raw) begin
      diff = {xs, EXP_ONES, {FRAC_W{1'b0}}};
      flg.overflow = 1'b1;
      flg.inexact  = 1'b1;
    end else begin
      diff = {rsign, exp_field, frac_out};
      flg.inexact   = inx_raw;
      flg.underflow = tiny & inx_raw;
    end
  end

  always_comb begin
    AST_INVALID_DEFAULT_NAN: assert (!flg.invalid || diff == QNAN_DEFAULT); // R6
    AST_OVF_GIVES_INF: assert (!flg.overflow || (diff[LANE_W-2:FRAC_W] == EXP_ONES && diff[FRAC_W-1:0] == '0)); // R8
    AST_UFL_TINY_RESULT: assert (!flg.underflow || diff[LANE_W-2:FRAC_W+1] == '0); // R9
  end

endmodule

// File: rtl/fpsub_lane_sel.sv
module fpsub_lane_sel
  import fpsub_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int LOW_LANES = 2
) (
  input  logic [1:0]                            mode,
  input  logic [NUM_LANES-1:0][LANE_W-1:0]      lane_res,
  input  fp_flags_t [NUM_LANES-1:0]             lane_flg,
  input  logic [NUM_LANES-1:0][LANE_W-1:0]      dst_prev,
  output logic [NUM_LANES-1:0][LANE_W-1:0]      vec_out,
  output fp_flags_t                             flg_out
);

  logic hi_calc, hi_zero;
  logic [NUM_LANES-1:0] lane_act;
  assign hi_calc = (mode == MODE_FULL) || (mode == MODE_FULL_X);
  assign hi_zero = (mode == MODE_ZERO_HI);

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_sel
    if (i < LOW_LANES) begin : g_low
      assign vec_out[i]  = lane_res[i];
      assign lane_act[i] = 1'b1;
    end else begin : g_high
      assign vec_out[i]  = hi_calc ? lane_res[i] : (hi_zero ? '0 : dst_prev[i]);
      assign lane_act[i] = hi_calc;
    end
  end

  always_comb begin
    flg_out = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (lane_act[i]) flg_out = flg_out | lane_flg[i];
    end
  end

endmodule

// File: rtl/pfp_sub_unit.sv
module pfp_sub_unit
  import fpsub_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int LOW_LANES = 2,
  localparam int VEC_W = NUM_LANES * LANE_W,
  localparam int FLG_W = $bits(fp_flags_t)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       mode,
  input  logic [VEC_W-1:0] src1,
  input  logic [VEC_W-1:0] src2,
  input  logic [VEC_W-1:0] dst_old,
  output logic             out_valid,
  output logic [VEC_W-1:0] result,
  output logic [FLG_W-1:0] flags
);

  logic [NUM_LANES-1:0][LANE_W-1:0] lane_res, dst_prev, sel_vec;
  fp_flags_t [NUM_LANES-1:0]        lane_flg;
  fp_flags_t                        sel_flg;

  assign dst_prev = dst_old;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    fpsub_lane u_lane (
      .op_a (src1[i*LANE_W +: LANE_W]),
      .op_b (src2[i*LANE_W +: LANE_W]),
      .diff (lane_res[i]),
      .flg  (lane_flg[i])
    );
  end

  fpsub_lane_sel #(
    .NUM_LANES (NUM_LANES),
    .LOW_LANES (LOW_LANES)
  ) u_sel (
    .mode     (mode),
    .lane_res (lane_res),
    .lane_flg (lane_flg),
    .dst_prev (dst_prev),
    .vec_out  (sel_vec),
    .flg_out  (sel_flg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= sel_vec;
        flags  <= sel_flg;
      end
    end
  end

  localparam int HI_LO = LOW_LANES * LANE_W;

  AST_KEEP_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == MODE_KEEP_HI) |=> result[VEC_W-1:HI_LO] == $past(dst_old[VEC_W-1:HI_LO])); // R3
  AST_ZERO_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == MODE_ZERO_HI) |=> result[VEC_W-1:HI_LO] == '0); // R4
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R12
  AST_VALID_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R12
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result) && $stable(flags)); // R12

endmodule

// File: tb/tb_pfp_sub_unit.sv
module tb_pfp_sub_unit;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic [255:0] src1 = '0, src2 = '0, dst_old = '0;
  logic         out_valid;
  logic [255:0] result;
  logic [4:0]   flags;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [63:0] QN = 64'hFFF8_0000_0000_0000;

  always #4 clk = ~clk;

  pfp_sub_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .src1(src1), .src2(src2), .dst_old(dst_old),
    .out_valid(out_valid), .result(result), .flags(flags)
  );

  function automatic bit is_nan(input logic [63:0] x);
    return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
  endfunction
  function automatic bit is_snan(input logic [63:0] x);
    return is_nan(x) && !x[51];
  endfunction
  function automatic bit is_inf(input logic [63:0] x);
    return (x[62:52] == 11'h7FF) && (x[51:0] == 0);
  endfunction
  function automatic bit is_sub(input logic [63:0] x);
    return (x[62:52] == 0) && (x[51:0] != 0);
  endfunction

  // Reference lane: specials by rule, finite values through host doubles,
  // exactness through an error-free two-sum.
  function automatic void ref_lane(input logic [63:0] a, input logic [63:0] b,
                                   output logic [63:0] r, output logic [4:0] f);
    real x, y, s, bp, ap, da, db;
    f = '0;
    f[1] = is_sub(a) || is_sub(b);
    if (is_snan(a) || is_snan(b)) begin r = QN; f[0] = 1; end
    else if (is_nan(a)) r = a;
    else if (is_nan(b)) r = b;
    else if (is_inf(a) && is_inf(b) && a[63] == b[63]) begin r = QN; f[0] = 1; end
    else if (is_inf(a)) r = a;
    else if (is_inf(b)) r = {~b[63], b[62:0]};
    else begin
      x = $bitstoreal(a);
      y = -$bitstoreal(b);
      s = x + y;
      r = $realtobits(s);
      if (r[62:52] == 11'h7FF) begin
        f[2] = 1; f[4] = 1;
      end else begin
        bp = s - x; ap = s - bp; db = y - bp; da = x - ap;
        if (da + db != 0.0) f[4] = 1;
        if (r[62:52] == 0 && f[4]) f[3] = 1;
      end
    end
  endfunction

  task automatic check(input string req, input logic [255:0] got, input logic [255:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Drive one operation and check outputs one cycle later.
  task automatic do_op(input string req, input logic [1:0] m, input logic [255:0] s1,
                       input logic [255:0] s2, input logic [255:0] d);
    logic [255:0] er;
    logic [4:0]   ef, lf;
    logic [63:0]  lr;
    er = '0; ef = '0;
    for (int i = 0; i < 4; i++) begin
      ref_lane(s1[i*64 +: 64], s2[i*64 +: 64], lr, lf);
      if (i < 2 || m[1]) begin
        er[i*64 +: 64] = lr;
        ef = ef | lf;
      end else if (m == 2'b00) er[i*64 +: 64] = d[i*64 +: 64];
    end
    @(negedge clk);
    in_valid = 1; mode = m; src1 = s1; src2 = s2; dst_old = d;
    @(negedge clk);
    in_valid = 0;
    check({req, " valid"}, {255'b0, out_valid}, 256'd1);
    check({req, " result"}, result, er);
    check({req, " flags"}, {251'b0, flags}, {251'b0, ef});
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  function automatic logic [63:0] rand_fp(input int near_e, input bit use_near);
    logic [63:0] v;
    int k, e;
    v = rnd64();
    k = $urandom % 20;
    if (use_near) begin
      e = near_e + int'($urandom % 7) - 3;
      if (e < 1) e = 1;
      if (e > 2046) e = 2046;
      v[62:52] = 11'(e);
    end else if (k == 0) begin v[62:52] = 11'h7FF; v[51:0] = 0; end
    else if (k == 1) begin v[62:52] = 11'h7FF; v[51] = 1; end
    else if (k == 2) begin v[62:52] = 11'h7FF; v[51] = 0; v[0] = 1; end
    else if (k == 3) v[62:0] = 0;
    else if (k < 6) v[62:52] = 0;
    else if (k == 6) v[62:52] = 11'h7FE;
    return v;
  endfunction

  logic [63:0] c_one   = 64'h3FF0_0000_0000_0000;
  logic [63:0] c_max   = 64'h7FEF_FFFF_FFFF_FFFF;

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL R12 watchdog: got running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [255:0] s1, s2, d;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12: reset state
    check("R12 reset valid", {255'b0, out_valid}, 256'd0);
    check("R12 reset result", result, 256'd0);
    check("R12 reset flags", {251'b0, flags}, 256'd0);

    d = {4{64'hDEAD_BEEF_0123_4567}};
    // R5 signed zeros
    do_op("R5 x-x", 2'b10, {c_one, 64'hBFF0_0000_0000_0000, 64'h8000_0000_0000_0000, c_one},
                          {c_one, 64'hBFF0_0000_0000_0000, 64'h0000_0000_0000_0000, c_one}, d);
    check("R5 -0 minus +0", {192'b0, result[127:64]}, {192'b0, 64'h8000_0000_0000_0000});
    check("R5 1-1 is +0", {192'b0, result[63:0]}, 256'd0);
    // R1 ties to even
    do_op("R1 ties", 2'b01, {128'b0, 64'h3FF0_0000_0000_0001, c_one},
                           {128'b0, 64'hBCA0_0000_0000_0000, 64'hBCA0_0000_0000_0000}, d);
    check("R1 tie to even up", {192'b0, result[127:64]}, {192'b0, 64'h3FF0_0000_0000_0002});
    check("R1 tie to even down", {192'b0, result[63:0]}, {192'b0, c_one});
    check("R9 tie inexact", {251'b0, flags}, {251'b0, 5'b10000});
    // R8 overflow
    do_op("R8 overflow", 2'b00, {128'b0, 64'h0, c_max}, {128'b0, 64'h0, {1'b1, c_max[62:0]}}, d);
    check("R8 +inf", {192'b0, result[63:0]}, {192'b0, 64'h7FF0_0000_0000_0000});
    check("R8 flags", {251'b0, flags}, {251'b0, 5'b10100});
    check("R3 upper kept", {128'b0, result[255:128]}, {128'b0, d[255:128]});
    // R10 / R9 subnormal exact
    do_op("R10 subnormal", 2'b01, {128'b0, 64'h3, 64'h3}, {128'b0, 64'h1, 64'h8000_0000_0000_0001}, d);
    check("R10 sub diff", {192'b0, result[63:0]}, {192'b0, 64'h4});
    check("R9 R10 flags exact denormal", {251'b0, flags}, {251'b0, 5'b00010});
    // R6 invalid
    do_op("R6 inf-inf", 2'b01, {128'b0, 64'h7FF0_0000_0000_0001, 64'h7FF0_0000_0000_0000},
                              {128'b0, c_one, 64'h7FF0_0000_0000_0000}, d);
    check("R6 default nan", result[127:0], {QN, QN});
    check("R6 invalid flag", {251'b0, flags}, {251'b0, 5'b00001});
    // R7 quiet nan priority
    do_op("R7 qnan", 2'b01, {128'b0, c_one, 64'h7FF8_0000_0000_0011},
                           {128'b0, 64'hFFF8_0000_0000_0022, 64'hFFF8_0000_0000_0022}, d);
    check("R7 first nan wins", {192'b0, result[63:0]}, {192'b0, 64'h7FF8_0000_0000_0011});
    check("R7 second nan kept", {192'b0, result[127:64]}, {192'b0, 64'hFFF8_0000_0000_0022});
    // R11 masked lanes contribute no flags; R4 zero upper
    do_op("R11 masked", 2'b01, {64'h7FF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, c_one, c_one},
                              {64'h7FF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, c_one, c_one}, d);
    check("R11 no flags from lanes 2,3", {251'b0, flags}, 256'd0);
    check("R4 upper zero", {128'b0, result[255:128]}, 256'd0);
    // R2 full width with mode 11
    do_op("R2 mode11", 2'b11, {64'h7FF0_0000_0000_0000, c_one, c_one, c_one},
                             {64'h7FF0_0000_0000_0000, 64'h3FF8_0000_0000_0000, c_one, c_one}, d);
    check("R2 lane2", {192'b0, result[191:128]}, {192'b0, 64'hBFE0_0000_0000_0000});
    check("R11 R2 lane3 invalid", {251'b0, flags}, {251'b0, 5'b00001});
    // R12: idle cycle drops valid and holds result
    s1 = result;
    @(negedge clk);
    check("R12 valid one cycle", {255'b0, out_valid}, 256'd0);
    check("R12 hold result", result, s1);

    // Random phase
    for (int n = 0; n < 400; n++) begin
      logic [63:0] a, b;
      logic [1:0] m;
      for (int i = 0; i < 4; i++) begin
        a = rand_fp(0, 0);
        b = ($urandom % 2 == 1 && a[62:52] != 0 && a[62:52] != 11'h7FF)
            ? rand_fp(int'(a[62:52]), 1) : rand_fp(0, 0);
        s1[i*64 +: 64] = a;
        s2[i*64 +: 64] = b;
      end
      d = {rnd64(), rnd64(), rnd64(), rnd64()};
      m = 2'($urandom % 4);
      do_op("R1 R2 R3 R4 random", m, s1, s2, d);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule